// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from the moment power and clock are reported good to the point where ordinary traffic may begin. After reset it holds clock-enable low and drives NOP. The input `pwr_stable` starts the sequence. The block then waits a settle interval, which it derives from a clock-frequency parameter and a microsecond parameter. When that interval ends it raises clock-enable on a NOP cycle and issues the bring-up commands in a fixed order:

- precharge of all banks;
- a write to the extended mode register that enables the DLL;
- a mode register write with the DLL-reset bit set;
- a second precharge of all banks;
- a parameterized number of auto refreshes;
- a final mode register write with the DLL-reset bit cleared.

Each command is followed by its own parameterized wait (precharge, refresh or mode-register spacing). Every cycle that carries no command carries NOP.

A separate DLL lock counter starts at the DLL-reset write and runs while the rest of the sequence continues. The ready flag `init_done` rises only after two things have happened: the final mode write has been spaced out, and the lock count has expired. The mode register contents are parameters.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: Synchronous active-high `rst` returns the block to the waiting state. In that state `cke`=0 and `init_done`=0, and the bus carries NOP ({cs_n,ras_n,cas_n,we_n}=0111) with `addr`=0 and `ba`=0. The block stays in this state for as long as `pwr_stable` is sampled low.
- R2: Let cycle c be the first cycle in which `pwr_stable` is sampled high. `cke` stays low up to and including cycle c+SETTLE, where SETTLE = CLK_MHZ*SETTLE_US. No command other than NOP appears while `cke` is low.
- R3: Cycle c+SETTLE+1 carries NOP and is the first cycle with `cke` high. The following cycle carries PRECHARGE ALL: code 0010, `addr` bit 10 = 1, all other address bits 0, `ba`=00.
- R4: T_RP cycles after that precharge, the extended mode register write appears: code 0000, `ba`=01, `addr`=EXT_MODE_REG. T_MRD cycles later, the mode register write appears: code 0000, `ba`=00, `addr`=MODE_REG with bit 8 set.
- R5: T_MRD cycles after the DLL-reset write, a second PRECHARGE ALL appears. T_RP cycles after that comes the first of REF_COUNT auto refreshes (code 0001, `addr`=0, `ba`=00), and each further refresh follows T_RFC cycles after the one before. REF_COUNT must be at least 2.
- R6: T_RFC cycles after the last refresh, a mode register write appears: code 0000, `ba`=00, `addr`=MODE_REG with bit 8 cleared.
- R7: Every cycle that is not one of the command cycles above carries NOP with `addr`=0 and `ba`=0.
- R8: Let D be the cycle of the DLL-reset write and F the cycle of the final mode write. `init_done` rises in cycle max(F+T_MRD, D+LOCK_CYC)+1. After that it stays high, with `cke` high and NOP on the bus, until reset.
- R9: Asserting `rst` partway through the sequence drops `cke` and `init_done` at once. The sequence then restarts from the beginning on the next `pwr_stable` high.
- R10: Once the sequence has started, `pwr_stable` going low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_stable | input | 1 | High once supplies and clock are stable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines (mode data, bit 10 for all-bank precharge) |
| ba | output | 2 | Bank address, also selects mode (00) or extended mode (01) register |
| init_done | output | 1 | Initialization complete |

## Verification
Two instances with different timing run from the same stimulus. In one, the DLL lock wait outlasts the command sequence. In the other, the final mode write ends later than the lock wait, and the precharge gap is a single cycle, so no wait states are inserted. A sequencer that waited on only one of the two conditions, or that padded a one-cycle gap, would raise `init_done` or a command in the wrong cycle.

The bench also drops `pwr_stable` during the settle interval. A design that still watched this input would stall or restart.

It also resets the block in the middle of the refresh phase. A design that kept its refresh count, its lock state or clock-enable would then resume partway through the sequence instead of starting again.

Two further faults are caught on every cycle: a mode write that leaves the DLL-reset bit at the wrong value, and a refresh count that is off by one.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Sequencer states, in issue order
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CKE_NOP,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_DLLRST,
        ST_PRE_B,
        ST_AREF,
        ST_MRS_FINAL,
        ST_GAP,
        ST_LOCK_WAIT,
        ST_READY
    } seq_state_e;

    // Command code as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_PRE  = 4'b0010,
        CMD_AREF = 4'b0001,
        CMD_MRS  = 4'b0000
    } ddr_cmd_e;

    // Register select on the bank lines during a mode write
    typedef enum logic [1:0] {
        REGSEL_MODE = 2'b00,
        REGSEL_EXT  = 2'b01
    } reg_sel_e;

    localparam int unsigned ALLBANK_BIT = 10;
    localparam int unsigned DLLRST_BIT  = 8;

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_downcnt.sv
module ddr_init_downcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    // R2: a running count steps down by one per cycle
    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && count != '0) |=> (count == $past(count) - 1'b1));

    // R8: an expired count stays expired until reloaded
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> (count == '0));

endmodule

// File: rtl/ddr_init_cmd_map.sv
module ddr_init_cmd_map
    import ddr_init_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 13,
    parameter logic [ADDR_W-1:0] MODE_REG     = 'h032,
    parameter logic [ADDR_W-1:0] EXT_MODE_REG = 'h000
) (
    input  seq_state_e        state,
    output ddr_cmd_e          cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLLRST_BIT;
    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << ALLBANK_BIT;

    always_comb begin
        cmd  = CMD_NOP;
        ba   = 2'b00;
        addr = '0;
        unique case (state)
            ST_PRE_A, ST_PRE_B: begin
                cmd  = CMD_PRE;
                addr = PRE_ADDR;
            end
            ST_EMRS: begin
                cmd  = CMD_MRS;
                ba   = REGSEL_EXT;
                addr = EXT_MODE_REG;
            end
            ST_MRS_DLLRST: begin
                cmd  = CMD_MRS;
                ba   = REGSEL_MODE;
                addr = MODE_REG | DLL_MASK;
            end
            ST_MRS_FINAL: begin
                cmd  = CMD_MRS;
                ba   = REGSEL_MODE;
                addr = MODE_REG & ~DLL_MASK;
            end
            ST_AREF: cmd = CMD_AREF;
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 13,
    parameter int unsigned       CLK_MHZ      = 125,
    parameter int unsigned       SETTLE_US    = 200,
    parameter int unsigned       LOCK_CYC     = 200,
    parameter int unsigned       T_RP         = 3,
    parameter int unsigned       T_RFC        = 10,
    parameter int unsigned       T_MRD        = 2,
    parameter int unsigned       REF_COUNT    = 2,
    parameter logic [ADDR_W-1:0] MODE_REG     = 'h032,
    parameter logic [ADDR_W-1:0] EXT_MODE_REG = 'h000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_stable,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba,
    output logic              init_done
);

    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int unsigned WAIT_MAX   = umax(umax(SETTLE_CYC, T_RP), umax(T_RFC, T_MRD));
    localparam int unsigned WAIT_W     = $clog2(WAIT_MAX + 1);
    localparam int unsigned LOCK_W     = $clog2(LOCK_CYC + 1);
    localparam int unsigned REF_W      = $clog2(REF_COUNT + 1);

    if (REF_COUNT < 2) begin : g_bad_refcount
        initial $error("REF_COUNT must be at least 2");
    end

    seq_state_e        state_q, state_d, after_q, after_d;
    logic [REF_W-1:0]  ref_q, ref_d;
    logic              wt_load;
    logic [WAIT_W-1:0] wt_val, wt_cnt;
    logic              lock_armed_q, lock_done;
    logic [LOCK_W-1:0] lock_cnt;
    ddr_cmd_e          cmd;

    // Shared settle/gap timer
    ddr_init_downcnt #(.W(WAIT_W)) u_gap_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (wt_load),
        .load_val (wt_val),
        .count    (wt_cnt)
    );

    // DLL lock timer, runs alongside the command sequence
    ddr_init_downcnt #(.W(LOCK_W)) u_lock_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_MRS_DLLRST),
        .load_val (LOCK_W'(LOCK_CYC - 1)),
        .count    (lock_cnt)
    );

    assign lock_done = lock_armed_q && (lock_cnt == '0);

    always_comb begin
        state_d = state_q;
        after_d = after_q;
        ref_d   = ref_q;
        wt_load = 1'b0;
        wt_val  = '0;
        unique case (state_q)
            ST_IDLE: if (pwr_stable) begin
                state_d = ST_SETTLE;
                wt_load = 1'b1;
                wt_val  = WAIT_W'(SETTLE_CYC);
            end
            ST_SETTLE:  if (wt_cnt == WAIT_W'(1)) state_d = ST_CKE_NOP;
            ST_CKE_NOP: state_d = ST_PRE_A;
            ST_PRE_A: begin
                after_d = ST_EMRS;
                if (T_RP > 1) begin
                    state_d = ST_GAP; wt_load = 1'b1; wt_val = WAIT_W'(T_RP - 1);
                end else state_d = ST_EMRS;
            end
            ST_EMRS: begin
                after_d = ST_MRS_DLLRST;
                if (T_MRD > 1) begin
                    state_d = ST_GAP; wt_load = 1'b1; wt_val = WAIT_W'(T_MRD - 1);
                end else state_d = ST_MRS_DLLRST;
            end
            ST_MRS_DLLRST: begin
                after_d = ST_PRE_B;
                if (T_MRD > 1) begin
                    state_d = ST_GAP; wt_load = 1'b1; wt_val = WAIT_W'(T_MRD - 1);
                end else state_d = ST_PRE_B;
            end
            ST_PRE_B: begin
                ref_d   = REF_W'(REF_COUNT);
                after_d = ST_AREF;
                if (T_RP > 1) begin
                    state_d = ST_GAP; wt_load = 1'b1; wt_val = WAIT_W'(T_RP - 1);
                end else state_d = ST_AREF;
            end
            ST_AREF: begin
                ref_d   = ref_q - 1'b1;
                after_d = (ref_q == REF_W'(1)) ? ST_MRS_FINAL : ST_AREF;
                if (T_RFC > 1) begin
                    state_d = ST_GAP; wt_load = 1'b1; wt_val = WAIT_W'(T_RFC - 1);
                end else state_d = after_d;
            end
            ST_MRS_FINAL: begin
                after_d = ST_LOCK_WAIT;
                if (T_MRD > 1) begin
                    state_d = ST_GAP; wt_load = 1'b1; wt_val = WAIT_W'(T_MRD - 1);
                end else state_d = ST_LOCK_WAIT;
            end
            ST_GAP:       if (wt_cnt == WAIT_W'(1)) state_d = after_q;
            ST_LOCK_WAIT: if (lock_done) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            after_q      <= ST_IDLE;
            ref_q        <= '0;
            lock_armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            ref_q   <= ref_d;
            if (state_q == ST_MRS_DLLRST) lock_armed_q <= 1'b1;
        end
    end

    ddr_init_cmd_map #(
        .ADDR_W       (ADDR_W),
        .MODE_REG     (MODE_REG),
        .EXT_MODE_REG (EXT_MODE_REG)
    ) u_cmd_map (
        .state (state_q),
        .cmd   (cmd),
        .ba    (ba),
        .addr  (addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke       = !(state_q inside {ST_IDLE, ST_SETTLE});
    assign init_done = (state_q == ST_READY);

    // R2: once raised, clock-enable never falls without reset
    p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R7: nothing but NOP while clock-enable is low
    p_quiet_cke_low_r7: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd == CMD_NOP));

    // R3: every precharge addresses all banks
    p_pre_allbank_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> addr[ALLBANK_BIT]);

    // R4: the DLL-reset bit only goes to the base mode register
    p_dllrst_target_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS && addr[DLLRST_BIT]) |-> (ba == REGSEL_MODE));

    // R8: ready only with the lock count expired, and it stays
    p_done_needs_lock_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> lock_done);
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

endmodule

// File: tb/ddr_pwrup_seq_bench.sv
module ddr_pwrup_seq_bench;

    localparam int CLK_MHZ   = 125;
    localparam int SETTLE_US = 1;
    localparam int SETTLE    = CLK_MHZ * SETTLE_US;

    // Instance A: lock wait dominates
    localparam int A_LOCK = 200, A_RP = 3, A_RFC = 10, A_MRD = 2, A_REF = 2;
    localparam logic [12:0] A_MODE = 13'h032, A_EXT = 13'h000;
    // Instance B: command sequence dominates, single-cycle precharge gap
    localparam int B_LOCK = 8, B_RP = 1, B_RFC = 5, B_MRD = 3, B_REF = 3;
    localparam logic [12:0] B_MODE = 13'h062, B_EXT = 13'h002;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic pwr_stable = 1'b0;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [12:0] a_addr;
    logic [1:0]  a_ba;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [12:0] b_addr;
    logic [1:0]  b_ba;

    ddr_pwrup_seq #(
        .ADDR_W(13), .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .LOCK_CYC(A_LOCK),
        .T_RP(A_RP), .T_RFC(A_RFC), .T_MRD(A_MRD), .REF_COUNT(A_REF),
        .MODE_REG(A_MODE), .EXT_MODE_REG(A_EXT)
    ) u_ddr_pwrup_seq (
        .clk(clk), .rst(rst), .pwr_stable(pwr_stable), .cke(a_cke),
        .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
        .addr(a_addr), .ba(a_ba), .init_done(a_done)
    );

    ddr_pwrup_seq #(
        .ADDR_W(13), .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .LOCK_CYC(B_LOCK),
        .T_RP(B_RP), .T_RFC(B_RFC), .T_MRD(B_MRD), .REF_COUNT(B_REF),
        .MODE_REG(B_MODE), .EXT_MODE_REG(B_EXT)
    ) u_ddr_pwrup_seq_b (
        .clk(clk), .rst(rst), .pwr_stable(pwr_stable), .cke(b_cke),
        .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
        .addr(b_addr), .ba(b_ba), .init_done(b_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int k       = 0;
    bit started = 1'b0;
    bit rst_mid = 1'b0;
    bit finished = 1'b0;

    // Expected {cke, cmd[3:0], ba, addr, done} in cycle k of a run
    function automatic logic [20:0] model(input int kk, input int trp, input int trfc,
                                          input int tmrd, input int nref, input int lock,
                                          input logic [12:0] mode, input logic [12:0] ext,
                                          output string tag);
        int knop  = SETTLE + 1;
        int kpre1 = knop + 1;
        int kemrs = kpre1 + trp;
        int kmrs  = kemrs + tmrd;
        int kpre2 = kmrs + tmrd;
        int kref0 = kpre2 + trp;
        int kfin  = kref0 + nref * trfc;
        int kdone;
        logic       e_cke  = 1'b0;
        logic [3:0] e_cmd  = 4'b0111;
        logic [1:0] e_ba   = 2'b00;
        logic [12:0] e_adr = 13'h0;
        logic       e_done = 1'b0;
        kdone = (((kfin + tmrd) > (kmrs + lock)) ? (kfin + tmrd) : (kmrs + lock)) + 1;
        tag = "R7";
        if (kk == 0) tag = "R1";
        else if (kk <= SETTLE) tag = "R2";
        else begin
            e_cke = 1'b1;
            if (kk == knop) tag = "R3";
            else if (kk == kpre1 || kk == kpre2) begin
                e_cmd = 4'b0010; e_adr = 13'h400;
                tag = (kk == kpre1) ? "R3" : "R5";
            end else if (kk == kemrs) begin
                e_cmd = 4'b0000; e_ba = 2'b01; e_adr = ext; tag = "R4";
            end else if (kk == kmrs) begin
                e_cmd = 4'b0000; e_adr = mode | 13'h100; tag = "R4";
            end else if (kk >= kref0 && kk < kfin && ((kk - kref0) % trfc) == 0) begin
                e_cmd = 4'b0001; tag = "R5";
            end else if (kk == kfin) begin
                e_cmd = 4'b0000; e_adr = mode & ~13'h100; tag = "R6";
            end else if (kk >= kdone) begin
                e_done = 1'b1; tag = "R8";
            end else if (kk >= kfin + tmrd) tag = "R8";
        end
        return {e_cke, e_cmd, e_ba, e_adr, e_done};
    endfunction

    task automatic check_one(input string who, input logic [20:0] act,
                             input logic [20:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s k=%0d actual=%h expected=%h", tag, who, k, act, exp);
        end
    endtask

    task automatic tick(input logic r, input logic p);
        string ta, tb;
        logic [20:0] ea, eb;
        rst = r;
        pwr_stable = p;
        @(posedge clk);
        if (r) begin
            k = 0; started = 1'b0;
        end else if (started) k++;
        else if (p) begin
            started = 1'b1; k = 1;
        end
        @(negedge clk);
        ea = model(k, A_RP, A_RFC, A_MRD, A_REF, A_LOCK, A_MODE, A_EXT, ta);
        eb = model(k, B_RP, B_RFC, B_MRD, B_REF, B_LOCK, B_MODE, B_EXT, tb);
        if (k == 0 && rst_mid) begin ta = "R9"; tb = "R9"; end
        if (started && !p) begin ta = "R10"; tb = "R10"; end
        check_one("A", {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done}, ea, ta);
        check_one("B", {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done}, eb, tb);
    endtask

    initial begin
        repeat (3)   tick(1'b1, 1'b0);   // R1 reset state
        repeat (10)  tick(1'b0, 1'b0);   // R1 hold while power not stable
        repeat (40)  tick(1'b0, 1'b1);   // R2 settle
        repeat (20)  tick(1'b0, 1'b0);   // R10 drop ignored mid-settle
        repeat (300) tick(1'b0, 1'b1);   // R3..R8 full run
        repeat (2)   tick(1'b1, 1'b0);
        repeat (140) tick(1'b0, 1'b1);   // into refresh phase
        rst_mid = 1'b1;
        repeat (2)   tick(1'b1, 1'b1);   // R9 reset mid-sequence
        repeat (5)   tick(1'b0, 1'b0);   // R9 waits again
        repeat (360) tick(1'b0, 1'b1);   // R9 full restart
        rst_mid = 1'b0;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired at k=%0d actual=hung expected=finished", k);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule